// File: doc/BRIEF.md
# Linked-Descriptor Byte Copy Channel

This block is a single copy engine. It moves a run of bytes from one address to another over a simple memory master port. Each byte is read from the source and then written to the destination. The source and destination addresses each step independently: up by one, down by one, or not at all. Software programs the channel through five 32-bit registers (byte count, source, destination, next-descriptor pointer and control) and starts it by raising the go bit in the control register.

In chained mode the channel walks a list of descriptors held in memory. Each descriptor is four consecutive 32-bit words. When a copy finishes, the channel loads the descriptor that the next pointer names and keeps going, until it reaches a next pointer of zero. Software can also load one descriptor without starting a copy by writing the self-clearing fetch bit. At the end of each copy the channel can raise a one-cycle completion cause on its interrupt output. A read-only busy flag shows whether the engine is running.

Top module: `dma_chain_chan`

## Requirements
- R1: Control bits [3:2] select the source step and bits [5:4] select the destination step. Code 0 adds one after each byte, code 1 subtracts one, code 2 holds the address constant, and code 3 behaves like code 0.
- R2: Register word 0 is the count. Only its low 16 bits give the number of bytes. Each byte is one byte read at the source address followed by one byte write at the destination address, and bits [31:16] of the count are never changed by a transfer.
- R3: A control write that takes bit 12 from 0 to 1 while the channel is idle starts a copy. While the copy runs, control bits 12 and 14 both read as 1. Writing bit 12 as 0 starts nothing.
- R4: Control bit 14 is a busy flag that a register write cannot set or clear.
- R5: Writing control bit 13 as 1 while idle in chained mode loads a descriptor without copying. The descriptor is four little-endian 32-bit words read at the next pointer plus 0, 4, 8 and 12, loaded in that order into count (word 0), source (word 1), destination (word 2) and next pointer (word 3). Bit 13 always reads as 0.
- R6: When control bit 9 is 1 (single mode), no descriptor is ever read. When bit 9 is 0, a next pointer of zero ends the chain. A fetch command that finds the chain at its end performs no memory access.
- R7: After a copy, source (word 1) and destination (word 2) hold the addresses as stepped past the last byte, and the low 16 bits of the count hold zero.
- R8: When a copy completes with control bit 10 at 0, bit 4+CHAN_ID of the cause output pulses for exactly one cycle. With bit 10 at 1, no pulse is raised.
- R9: In chained mode, after each completion the channel loads the next descriptor and copies it. It continues until the next pointer is zero, and then clears control bits 12 and 14.
- R10: A start with a count of zero moves no data and goes straight to completion handling.
- R11: A memory request keeps its address, direction and size unchanged until the acknowledge arrives.
- R12: While the channel is busy, writes to the count, source, destination and next registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index (0 count, 1 source, 2 destination, 3 next, 4 control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a byte write, 0 for a read |
| mem_word | output | 1 | 1 for a 32-bit descriptor read, 0 for a byte access |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 32 | Read data; a byte read returns the byte in bits [7:0] |
| mem_ack | input | 1 | Access complete |
| irq_cause | output | 8 | Completion cause, bit 4+CHAN_ID pulses |

## Verification
The assertions assume that mem_ack arrives only while mem_req is high, that it lasts a single cycle per access, and that register writes arrive as single-cycle strobes. The bench memory model raises the acknowledge one cycle after it sees a request and drops it again straight after, so every access waits on the acknowledge. All bench addresses stay within a 256-byte window, and the regions used for descriptors, sources and destinations are kept apart so that no copy overwrites a descriptor still to be read.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_READ, ST_WRITE, ST_DONE
  } chan_state_e;

  localparam logic [2:0] RA_COUNT = 3'd0;
  localparam logic [2:0] RA_SRC   = 3'd1;
  localparam logic [2:0] RA_DST   = 3'd2;
  localparam logic [2:0] RA_NEXT  = 3'd3;
  localparam logic [2:0] RA_CTRL  = 3'd4;

  localparam int BIT_SINGLE = 9;
  localparam int BIT_QUIET  = 10;
  localparam int BIT_GO     = 12;
  localparam int BIT_FETCH  = 13;
  localparam int BIT_BUSY   = 14;

  localparam logic [1:0] STEP_UP   = 2'd0;
  localparam logic [1:0] STEP_DOWN = 2'd1;
  localparam logic [1:0] STEP_HOLD = 2'd2;
endpackage

// File: rtl/dma_chain_step.sv
module dma_chain_step
  import dma_chain_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [1:0]    mode,
  input  logic [AW-1:0] cur,
  output logic [AW-1:0] nxt
);
  always_comb begin
    case (mode)
      STEP_DOWN: nxt = cur - AW'(1);
      STEP_HOLD: nxt = cur;
      default:   nxt = cur + AW'(1);
    endcase
  end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetch_cmd,
  input  logic        start_cmd,
  input  logic        single_mode,
  input  logic        next_zero,
  input  logic        cnt_zero,
  input  logic        cnt_one,
  input  logic        quiet,
  input  logic        mem_ack,
  output chan_state_e state_o,
  output logic [1:0]  word_idx,
  output logic        ld_word,
  output logic        step_xfer,
  output logic        chain_end,
  output logic        done_pulse
);
  chan_state_e state_q, state_n;
  logic [1:0]  idx_q, idx_n;
  logic        go_q, go_n;

  always_comb begin
    state_n    = state_q;
    idx_n      = idx_q;
    go_n       = go_q;
    ld_word    = 1'b0;
    step_xfer  = 1'b0;
    chain_end  = 1'b0;
    done_pulse = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (fetch_cmd) begin
          if (single_mode || next_zero) begin
            chain_end = 1'b1;
          end else begin
            state_n = ST_FETCH;
            idx_n   = 2'd0;
            go_n    = start_cmd;
          end
        end else if (start_cmd) begin
          state_n = ST_CHECK;
        end
      end
      ST_FETCH: begin
        if (mem_ack) begin
          ld_word = 1'b1;
          idx_n   = idx_q + 2'd1;
          if (idx_q == 2'd3) state_n = go_q ? ST_CHECK : ST_IDLE;
        end
      end
      ST_CHECK: state_n = cnt_zero ? ST_DONE : ST_READ;
      ST_READ: begin
        if (mem_ack) state_n = ST_WRITE;
      end
      ST_WRITE: begin
        if (mem_ack) begin
          step_xfer = 1'b1;
          state_n   = cnt_one ? ST_DONE : ST_READ;
        end
      end
      ST_DONE: begin
        done_pulse = !quiet;
        if (!single_mode && !next_zero) begin
          state_n = ST_FETCH;
          idx_n   = 2'd0;
          go_n    = 1'b1;
        end else begin
          chain_end = 1'b1;
          state_n   = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= 2'd0;
      go_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      go_q    <= go_n;
    end
  end

  assign state_o  = state_q;
  assign word_idx = idx_q;

  AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> (state_q != ST_WRITE) && (state_q != ST_READ)); // R3
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
  import dma_chain_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CNT_W   = 16,
  parameter int CHAN_ID = 0,
  parameter int CAUSE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic               mem_word,
  output logic [AW-1:0]      mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [31:0]        mem_rdata,
  input  logic               mem_ack,
  output logic [CAUSE_W-1:0] irq_cause
);
  localparam int CAUSE_BIT = 4 + CHAN_ID;

  logic [31:0]   cnt_q, cnt_n;
  logic [AW-1:0] src_q, src_n, dst_q, dst_n, nxt_q, nxt_n;
  logic [11:0]   ctl_q, ctl_n;
  logic          go_q, go_n;
  logic [7:0]    byte_q, byte_n;
  logic [AW-1:0] src_step, dst_step;

  chan_state_e state;
  logic [1:0]  word_idx;
  logic        ld_word, step_xfer, chain_end, done_pulse;
  logic        busy, ctl_wr, start_cmd, fetch_cmd;

  assign busy      = (state != ST_IDLE);
  assign ctl_wr    = reg_wr && (reg_addr == RA_CTRL);
  assign start_cmd = ctl_wr && reg_wdata[BIT_GO] && !go_q && !busy;
  assign fetch_cmd = ctl_wr && reg_wdata[BIT_FETCH] && !busy;

  dma_chain_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_cmd  (fetch_cmd),
    .start_cmd  (start_cmd),
    .single_mode(ctl_q[BIT_SINGLE]),
    .next_zero  (nxt_q == '0),
    .cnt_zero   (cnt_q[CNT_W-1:0] == '0),
    .cnt_one    (cnt_q[CNT_W-1:0] == CNT_W'(1)),
    .quiet      (ctl_q[BIT_QUIET]),
    .mem_ack    (mem_ack),
    .state_o    (state),
    .word_idx   (word_idx),
    .ld_word    (ld_word),
    .step_xfer  (step_xfer),
    .chain_end  (chain_end),
    .done_pulse (done_pulse)
  );

  dma_chain_step #(.AW(AW)) u_src_step (.mode(ctl_q[3:2]), .cur(src_q), .nxt(src_step));
  dma_chain_step #(.AW(AW)) u_dst_step (.mode(ctl_q[5:4]), .cur(dst_q), .nxt(dst_step));

  // memory master
  assign mem_req   = (state == ST_FETCH) || (state == ST_READ) || (state == ST_WRITE);
  assign mem_we    = (state == ST_WRITE);
  assign mem_word  = (state == ST_FETCH);
  assign mem_wdata = byte_q;
  always_comb begin
    case (state)
      ST_FETCH: mem_addr = nxt_q + AW'({word_idx, 2'b00});
      ST_WRITE: mem_addr = dst_q;
      default:  mem_addr = src_q;
    endcase
  end

  // register next state
  always_comb begin
    cnt_n  = cnt_q;
    src_n  = src_q;
    dst_n  = dst_q;
    nxt_n  = nxt_q;
    ctl_n  = ctl_q;
    go_n   = go_q;
    byte_n = byte_q;
    if (reg_wr && !busy) begin
      case (reg_addr)
        RA_COUNT: cnt_n = reg_wdata;
        RA_SRC:   src_n = reg_wdata[AW-1:0];
        RA_DST:   dst_n = reg_wdata[AW-1:0];
        RA_NEXT:  nxt_n = reg_wdata[AW-1:0];
        default:  ;
      endcase
    end
    if (ctl_wr) ctl_n = reg_wdata[11:0];
    if (chain_end)      go_n = 1'b0;
    else if (start_cmd) go_n = 1'b1;
    if (ld_word) begin
      case (word_idx)
        2'd0:    cnt_n = mem_rdata;
        2'd1:    src_n = mem_rdata[AW-1:0];
        2'd2:    dst_n = mem_rdata[AW-1:0];
        default: nxt_n = mem_rdata[AW-1:0];
      endcase
    end
    if ((state == ST_READ) && mem_ack) byte_n = mem_rdata[7:0];
    if (step_xfer) begin
      src_n = src_step;
      dst_n = dst_step;
      cnt_n[CNT_W-1:0] = cnt_q[CNT_W-1:0] - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      nxt_q  <= '0;
      ctl_q  <= '0;
      go_q   <= 1'b0;
      byte_q <= '0;
    end else begin
      cnt_q  <= cnt_n;
      src_q  <= src_n;
      dst_q  <= dst_n;
      nxt_q  <= nxt_n;
      ctl_q  <= ctl_n;
      go_q   <= go_n;
      byte_q <= byte_n;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_COUNT: reg_rdata = cnt_q;
      RA_SRC:   reg_rdata = 32'(src_q);
      RA_DST:   reg_rdata = 32'(dst_q);
      RA_NEXT:  reg_rdata = 32'(nxt_q);
      RA_CTRL: begin
        reg_rdata[11:0]     = ctl_q;
        reg_rdata[BIT_GO]   = go_q;
        reg_rdata[BIT_BUSY] = busy;
      end
      default:  ;
    endcase
  end

  always_comb begin
    irq_cause = '0;
    irq_cause[CAUSE_BIT] = done_pulse;
  end

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_word)); // R11
  AST_GO_WHILE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHECK || state == ST_READ || state == ST_WRITE) |-> go_q); // R3
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !step_xfer && !ld_word |=> $stable(src_q) && $stable(dst_q)); // R12
  AST_CAUSE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cause != '0) |=> (irq_cause == '0)); // R8
  AST_HOLD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    step_xfer && (ctl_q[3:2] == STEP_HOLD) |=> $stable(src_q)); // R1
endmodule

// File: tb/dma_chain_chan_tb.sv
`timescale 1ns/1ps
module dma_chain_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_word;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [31:0] mem_rdata = 32'd0;
  logic        mem_ack = 1'b0;
  logic [7:0]  irq_cause;

  int n_chk = 0, n_bad = 0, n_wr = 0, n_rd = 0, n_irq = 0;
  logic [7:0] mem [256];

  always #4 clk = ~clk;

  dma_chain_chan u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .irq_cause(irq_cause)
  );

  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        n_wr <= n_wr + 1;
      end else begin
        n_rd <= n_rd + 1;
        if (mem_word)
          mem_rdata <= {mem[mem_addr[7:0] + 8'd3], mem[mem_addr[7:0] + 8'd2],
                        mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]};
        else
          mem_rdata <= {24'd0, mem[mem_addr[7:0]]};
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  always @(posedge clk) if (irq_cause[4]) n_irq <= n_irq + 1;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(string req);
    logic [31:0] c;
    int k;
    k = 0;
    do begin
      rd(3'd4, c);
      k++;
    end while (c[14] && k < 3000);
    if (k >= 3000) chk({req, " timeout"}, 32'd1, 32'd0);
  endtask

  task automatic put_word(int a, logic [31:0] w);
    for (int i = 0; i < 4; i++) mem[a + i] = w[8*i +: 8];
  endtask

  task automatic setup(logic [31:0] c, logic [31:0] s, logic [31:0] d, logic [31:0] n);
    wr(3'd0, c); wr(3'd1, s); wr(3'd2, d); wr(3'd3, n);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 5; i++) begin
      rd(3'(i), v);
      chk("R3 reset register", v, 32'd0);
    end
    chk("R11 reset request", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_inc_copy();
    logic [31:0] v;
    int w0, i0;
    w0 = n_wr; i0 = n_irq;
    setup(32'hABCD_0004, 32'h10, 32'h40, 32'h0);
    wr(3'd4, 32'h1200);
    rd(3'd4, v);
    chk("R3 running flags", {30'd0, v[14], v[12]}, 32'd3);
    wait_idle("R3");
    for (int i = 0; i < 4; i++) chk("R11 R2 copied byte", {24'd0, mem[8'h40 + i]}, {24'd0, pat(16 + i)});
    rd(3'd1, v); chk("R7 source final", v, 32'h14);
    rd(3'd2, v); chk("R7 dest final", v, 32'h44);
    rd(3'd0, v); chk("R2 R7 count final", v, 32'hABCD_0000);
    rd(3'd4, v); chk("R9 flags cleared", {30'd0, v[14], v[12]}, 32'd0);
    chk("R2 byte writes", 32'(n_wr - w0), 32'd4);
    chk("R8 one cause pulse", 32'(n_irq - i0), 32'd1);
  endtask

  task automatic t_dec_hold();
    logic [31:0] v;
    int w0;
    w0 = n_wr;
    setup(32'd3, 32'h22, 32'h60, 32'h0);
    wr(3'd4, 32'h1200 | 32'h24);
    wait_idle("R1");
    chk("R1 held dest last byte", {24'd0, mem[8'h60]}, {24'd0, pat(32)});
    rd(3'd1, v); chk("R1 source decremented", v, 32'h1F);
    rd(3'd2, v); chk("R1 dest held", v, 32'h60);
    chk("R2 writes count", 32'(n_wr - w0), 32'd3);
  endtask

  task automatic t_hold_dec();
    logic [31:0] v;
    setup(32'd2, 32'h30, 32'h71, 32'h0);
    wr(3'd4, 32'h1200 | 32'h18);
    wait_idle("R1");
    chk("R1 dest dec byte hi", {24'd0, mem[8'h71]}, {24'd0, pat(48)});
    chk("R1 dest dec byte lo", {24'd0, mem[8'h70]}, {24'd0, pat(48)});
    rd(3'd2, v); chk("R1 dest decremented", v, 32'h6F);
    rd(3'd1, v); chk("R1 source held", v, 32'h30);
  endtask

  task automatic t_quiet();
    int i0, w0;
    i0 = n_irq; w0 = n_wr;
    setup(32'd1, 32'h11, 32'h50, 32'h0);
    wr(3'd4, 32'h1600);
    wait_idle("R8");
    chk("R8 quiet no pulse", 32'(n_irq - i0), 32'd0);
    chk("R8 quiet still copies", 32'(n_wr - w0), 32'd1);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    int i0, w0;
    i0 = n_irq; w0 = n_wr;
    setup(32'h0, 32'h12, 32'h52, 32'h0);
    wr(3'd4, 32'h1200);
    wait_idle("R10");
    chk("R10 zero count no data", 32'(n_wr - w0), 32'd0);
    chk("R10 zero count completes", 32'(n_irq - i0), 32'd1);
    rd(3'd1, v); chk("R10 source untouched", v, 32'h12);
  endtask

  task automatic t_bits();
    logic [31:0] v;
    int r0, w0;
    wr(3'd4, 32'h4200);
    rd(3'd4, v); chk("R4 busy not writable", v, 32'h0200);
    r0 = n_rd; w0 = n_wr;
    setup(32'd2, 32'h10, 32'h58, 32'h80);
    wr(3'd4, 32'h2200);
    repeat (10) @(negedge clk);
    chk("R6 single mode no fetch", 32'(n_rd - r0), 32'd0);
    rd(3'd4, v); chk("R5 fetch bit reads zero", v, 32'h0200);
    wr(3'd4, 32'h0000);
    repeat (10) @(negedge clk);
    chk("R3 no start without go", 32'(n_wr - w0), 32'd0);
  endtask

  task automatic t_fetch();
    logic [31:0] v;
    int r0, w0;
    put_word(8'h80, 32'd5); put_word(8'h84, 32'h10);
    put_word(8'h88, 32'h90); put_word(8'h8C, 32'h0);
    r0 = n_rd; w0 = n_wr;
    setup(32'd0, 32'd0, 32'd0, 32'h80);
    wr(3'd4, 32'h2000);
    wait_idle("R5");
    rd(3'd0, v); chk("R5 loaded count", v, 32'd5);
    rd(3'd1, v); chk("R5 loaded source", v, 32'h10);
    rd(3'd2, v); chk("R5 loaded dest", v, 32'h90);
    rd(3'd3, v); chk("R5 loaded next", v, 32'h0);
    chk("R5 four word reads", 32'(n_rd - r0), 32'd4);
    chk("R5 no copy", 32'(n_wr - w0), 32'd0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    int i0;
    put_word(8'h80, 32'd2); put_word(8'h84, 32'h10);
    put_word(8'h88, 32'hA0); put_word(8'h8C, 32'hC0);
    put_word(8'hC0, 32'd3); put_word(8'hC4, 32'h14);
    put_word(8'hC8, 32'hB0); put_word(8'hCC, 32'h0);
    i0 = n_irq;
    setup(32'd0, 32'd0, 32'd0, 32'h80);
    wr(3'd4, 32'h1000);
    wait_idle("R9");
    chk("R9 first block", {24'd0, mem[8'hA1]}, {24'd0, pat(17)});
    chk("R9 second block", {24'd0, mem[8'hB2]}, {24'd0, pat(22)});
    chk("R9 three completions", 32'(n_irq - i0), 32'd3);
    rd(3'd1, v); chk("R9 final source", v, 32'h17);
    rd(3'd2, v); chk("R9 final dest", v, 32'hB3);
    rd(3'd3, v); chk("R6 chain end pointer", v, 32'h0);
    rd(3'd4, v); chk("R9 flags cleared", {30'd0, v[14], v[12]}, 32'd0);
  endtask

  task automatic t_frozen();
    logic [31:0] v;
    setup(32'd20, 32'h0, 32'hD0, 32'h0);
    wr(3'd4, 32'h1200);
    wr(3'd1, 32'hEE);
    wr(3'd0, 32'h55);
    wait_idle("R12");
    rd(3'd1, v); chk("R12 source write ignored", v, 32'd20);
    rd(3'd0, v); chk("R12 count write ignored", v, 32'd0);
    chk("R12 last byte", {24'd0, mem[8'hE3]}, {24'd0, pat(19)});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_inc_copy();
    t_dec_hold();
    t_hold_dec();
    t_quiet();
    t_zero();
    t_bits();
    t_fetch();
    t_chain();
    t_frozen();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule